// File: doc/BRIEF.md
# Receive Buffer Mode Selector and DMA Request Timer

This block chooses how a network controller buffers received frames and decides the cycle in which a receive DMA request goes to the host bus. Three buffering modes exist. In no-SRAM mode, the controller works from one transmit FIFO and one receive FIFO. In normal SRAM mode, frames pass through external SRAM. In low-latency bypass mode, received data skips the SRAM while transmit traffic still uses it. The mode comes from the configured SRAM size and a low-latency enable bit. A new configuration takes effect only in cycles where the controller reports that it is stopped. A change made while the controller runs is held back until it next stops.

A per-frame byte counter drives a small state machine with four named states. `ST_IDLE` waits for a frame start. `ST_COUNT` counts received bytes. `ST_REQ` holds the DMA request until the frame ends. `ST_FLUSH` requests for a single cycle when a short frame ends before it reaches its threshold. The transitions are as follows. Start-of-frame goes from any state to `ST_COUNT` and clears the counter. Reaching the threshold moves `ST_COUNT` to `ST_REQ`. End-of-frame moves `ST_COUNT` to `ST_FLUSH` if the frame held at least one byte, and to `ST_IDLE` otherwise. End-of-frame moves `ST_REQ` to `ST_IDLE`. `ST_FLUSH` always moves to `ST_IDLE`. A stopped controller forces `ST_IDLE`. The threshold is 16 bytes in bypass mode, which does not wait out the collision window. It is 64 bytes in the two other modes.

Top module: `rx_path_ctrl`

## Requirements
- R1: After reset, `rx_mode` is 0 (no-SRAM), `bnd_valid` is 0 and `dma_req` is 0.
- R2: While `ctl_stopped` is 1, a `cfg_sram_size` of 0 gives `rx_mode` 0 (no-SRAM) and `bnd_valid` 0 one cycle later, whatever `cfg_lowlat_en` holds.
- R3: While `ctl_stopped` is 1, a non-zero size with `cfg_lowlat_en` 0 gives `rx_mode` 1 (normal SRAM) and `bnd_valid` 1 one cycle later.
- R4: While `ctl_stopped` is 1, a non-zero size with `cfg_lowlat_en` 1 gives `rx_mode` 2 (low-latency bypass) and `bnd_valid` 0 one cycle later.
- R5: While `ctl_stopped` is 0, configuration changes do not alter `rx_mode`. The pending setting appears one cycle after `ctl_stopped` returns to 1.
- R6: In mode 2, `dma_req` rises in the cycle after the 16th `rx_byte_vld` of a frame.
- R7: In modes 0 and 1, `dma_req` rises in the cycle after the 64th `rx_byte_vld` of a frame.
- R8: If `rx_eof` arrives before the threshold and after at least one byte, `dma_req` is high for exactly the one cycle after `rx_eof`. An `rx_eof` with zero bytes raises no request.
- R9: If `rx_eof` arrives while `dma_req` is high, `dma_req` is low in the next cycle.
- R10: `rx_sof` clears the byte count. A new frame needs its full threshold again, even if it starts while a request is active.
- R11: `ctl_stopped` at 1 drops `dma_req` in the next cycle and stops counting. Bytes outside a frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sram_size | input | 8 | Configured SRAM size, 0 means none present |
| cfg_lowlat_en | input | 1 | Low-latency receive enable |
| ctl_stopped | input | 1 | Controller is in the stopped state |
| rx_sof | input | 1 | Frame start pulse from the receive MAC |
| rx_byte_vld | input | 1 | One received byte this cycle |
| rx_eof | input | 1 | Frame end pulse, a byte in the same cycle is not counted |
| rx_mode | output | 2 | Applied mode: 0 no-SRAM, 1 SRAM, 2 low-latency |
| bnd_valid | output | 1 | Buffer-boundary setting is in use (mode 1 only) |
| dma_req | output | 1 | Receive DMA request |

## Verification
Each result is due exactly one clock edge after its cause. `rx_mode` and `bnd_valid` follow the configuration sampled at the edge where `ctl_stopped` is 1. `dma_req` follows the edge that takes the threshold byte, the `rx_eof`, the `rx_sof` or the stop. The bench drives inputs on the falling edge and samples at the next falling edge, so every check sits one edge after its stimulus. It sweeps frame lengths from 0 to 70 bytes in every mode, and before each later byte and at `rx_eof` it compares `dma_req` with the arithmetic expectation.

// File: rtl/rx_path_pkg.sv
package rx_path_pkg;
    typedef enum logic [1:0] {
        MODE_NOSRAM = 2'd0,
        MODE_SRAM   = 2'd1,
        MODE_LOWLAT = 2'd2
    } rx_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_REQ   = 2'd2,
        ST_FLUSH = 2'd3
    } dma_st_e;
endpackage

// File: rtl/rx_mode_sel.sv
module rx_mode_sel
    import rx_path_pkg::*;
#(
    parameter int SIZE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SIZE_W-1:0] cfg_sram_size,
    input  logic              cfg_lowlat_en,
    input  logic              ctl_stopped,
    output rx_mode_e          mode_q
);
    rx_mode_e mode_d;

    always_comb begin
        if (cfg_sram_size == '0)
            mode_d = MODE_NOSRAM;
        else if (cfg_lowlat_en)
            mode_d = MODE_LOWLAT;
        else
            mode_d = MODE_SRAM;
    end

    // Configuration is only applied while the controller is stopped.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode_q <= MODE_NOSRAM;
        else if (ctl_stopped)
            mode_q <= mode_d;
    end
endmodule

// File: rtl/rx_byte_cnt.sv
module rx_byte_cnt #(
    parameter int CNT_W = 7,
    parameter int MAX_V = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(MAX_V);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc && cnt != SAT)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rx_dma_fsm.sv
module rx_dma_fsm
    import rx_path_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_stopped,
    input  logic             rx_sof,
    input  logic             rx_byte_vld,
    input  logic             rx_eof,
    input  logic [CNT_W-1:0] thr,
    input  logic [CNT_W-1:0] cnt,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output logic             dma_req
);
    dma_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (ctl_stopped)
            st_d = ST_IDLE;
        else if (rx_sof)
            st_d = ST_COUNT;
        else begin
            unique case (st_q)
                ST_IDLE:  st_d = ST_IDLE;
                ST_COUNT: begin
                    if (rx_eof)
                        st_d = (cnt != '0) ? ST_FLUSH : ST_IDLE;
                    else if (rx_byte_vld && cnt == thr - 1'b1)
                        st_d = ST_REQ;
                end
                ST_REQ:   if (rx_eof) st_d = ST_IDLE;
                ST_FLUSH: st_d = ST_IDLE;
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cnt_clr = ctl_stopped || rx_sof;
        cnt_inc = (st_q == ST_COUNT) && rx_byte_vld && !rx_eof;
        dma_req = (st_q == ST_REQ) || (st_q == ST_FLUSH);
    end
endmodule

// File: rtl/rx_path_ctrl.sv
module rx_path_ctrl
    import rx_path_pkg::*;
#(
    parameter int SIZE_W  = 8,
    parameter int LL_THR  = 16,
    parameter int COL_WIN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SIZE_W-1:0] cfg_sram_size,
    input  logic              cfg_lowlat_en,
    input  logic              ctl_stopped,
    input  logic              rx_sof,
    input  logic              rx_byte_vld,
    input  logic              rx_eof,
    output logic [1:0]        rx_mode,
    output logic              bnd_valid,
    output logic              dma_req
);
    localparam int CNT_W = $clog2(COL_WIN + 1);
    localparam logic [CNT_W-1:0] THR_LL  = CNT_W'(LL_THR);
    localparam logic [CNT_W-1:0] THR_COL = CNT_W'(COL_WIN);

    rx_mode_e         mode_q;
    logic [CNT_W-1:0] cnt, thr;
    logic             cnt_clr, cnt_inc;

    rx_mode_sel #(.SIZE_W(SIZE_W)) u_mode (
        .clk(clk), .rst_n(rst_n), .cfg_sram_size(cfg_sram_size),
        .cfg_lowlat_en(cfg_lowlat_en), .ctl_stopped(ctl_stopped),
        .mode_q(mode_q)
    );

    rx_byte_cnt #(.CNT_W(CNT_W), .MAX_V(COL_WIN)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .cnt(cnt)
    );

    always_comb thr = (mode_q == MODE_LOWLAT) ? THR_LL : THR_COL;

    rx_dma_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ctl_stopped(ctl_stopped),
        .rx_sof(rx_sof), .rx_byte_vld(rx_byte_vld), .rx_eof(rx_eof),
        .thr(thr), .cnt(cnt), .cnt_clr(cnt_clr), .cnt_inc(cnt_inc),
        .dma_req(dma_req)
    );

    always_comb begin
        rx_mode   = mode_q;
        bnd_valid = (mode_q == MODE_SRAM);
    end
endmodule

// File: rtl/rx_path_ctrl_chk.sv
module rx_path_ctrl_chk #(
    parameter int SIZE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SIZE_W-1:0] cfg_sram_size,
    input logic              cfg_lowlat_en,
    input logic              ctl_stopped,
    input logic              rx_sof,
    input logic              rx_eof,
    input logic [1:0]        rx_mode,
    input logic              bnd_valid,
    input logic              dma_req
);
    p_nosram_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_stopped && cfg_sram_size == '0 |=> rx_mode == 2'd0 && !bnd_valid);

    p_lowlat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_stopped && cfg_sram_size != '0 && cfg_lowlat_en |=> rx_mode == 2'd2 && !bnd_valid);

    p_hold_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_stopped |=> $stable(rx_mode));

    p_eof_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && rx_eof && !rx_sof && !ctl_stopped |=> !dma_req);

    p_stop_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_stopped |=> !dma_req);

    p_sof_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sof |=> !dma_req);
endmodule

bind rx_path_ctrl rx_path_ctrl_chk #(.SIZE_W(SIZE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_sram_size(cfg_sram_size),
    .cfg_lowlat_en(cfg_lowlat_en), .ctl_stopped(ctl_stopped),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_mode(rx_mode),
    .bnd_valid(bnd_valid), .dma_req(dma_req)
);

// File: tb/rx_path_ctrl_test.sv
`timescale 1ns/1ps
module rx_path_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_sram_size = 8'd0;
    logic       cfg_lowlat_en = 1'b0;
    logic       ctl_stopped = 1'b1;
    logic       rx_sof = 1'b0, rx_byte_vld = 1'b0, rx_eof = 1'b0;
    logic [1:0] rx_mode;
    logic       bnd_valid, dma_req;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rx_path_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_sram_size(cfg_sram_size),
        .cfg_lowlat_en(cfg_lowlat_en), .ctl_stopped(ctl_stopped),
        .rx_sof(rx_sof), .rx_byte_vld(rx_byte_vld), .rx_eof(rx_eof),
        .rx_mode(rx_mode), .bnd_valid(bnd_valid), .dma_req(dma_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_cfg(input logic [7:0] sz, input logic ll);
        cfg_sram_size = sz; cfg_lowlat_en = ll; ctl_stopped = 1'b1;
        step();
        ctl_stopped = 1'b0;
    endtask

    // Frame of n bytes; threshold thr; checks dma_req after each edge.
    task automatic frame(input int n, input int thr, input string req);
        rx_sof = 1'b1; step(); rx_sof = 1'b0;
        chk("R10", dma_req, 0);
        for (int i = 1; i <= n; i++) begin
            rx_byte_vld = 1'b1; step(); rx_byte_vld = 1'b0;
            chk(req, dma_req, (i >= thr) ? 1 : 0);
        end
        rx_eof = 1'b1; step(); rx_eof = 1'b0;
        if (n >= thr) chk("R9", dma_req, 0);
        else chk("R8", dma_req, (n >= 1) ? 1 : 0);
        step();
        chk("R8", dma_req, 0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(); step();
        chk("R1", rx_mode, 0); chk("R1", bnd_valid, 0); chk("R1", dma_req, 0);
        rst_n = 1'b1;
        step();
        // R2..R4 sweep of configuration while stopped
        for (int s = 0; s < 4; s++) begin
            for (int l = 0; l < 2; l++) begin
                cfg_sram_size = (s == 3) ? 8'hFF : 8'(s);
                cfg_lowlat_en = l[0];
                step();
                if (s == 0) begin
                    chk("R2", rx_mode, 0); chk("R2", bnd_valid, 0);
                end else if (l == 0) begin
                    chk("R3", rx_mode, 1); chk("R3", bnd_valid, 1);
                end else begin
                    chk("R4", rx_mode, 2); chk("R4", bnd_valid, 0);
                end
            end
        end
        // R5: change while running is deferred
        set_cfg(8'd4, 1'b0);
        cfg_sram_size = 8'd4; cfg_lowlat_en = 1'b1;
        for (int k = 0; k < 5; k++) begin
            step(); chk("R5", rx_mode, 1);
        end
        cfg_sram_size = 8'd0;
        step(); chk("R5", rx_mode, 1);
        ctl_stopped = 1'b1; step(); chk("R5", rx_mode, 0);
        // R11: bytes outside a frame ignored
        set_cfg(8'd8, 1'b1);
        for (int k = 0; k < 20; k++) begin
            rx_byte_vld = 1'b1; step(); chk("R11", dma_req, 0);
        end
        rx_byte_vld = 1'b0;
        // Frame-length sweeps in all three modes
        for (int n = 0; n <= 70; n++) frame(n, 16, "R6");
        set_cfg(8'd8, 1'b0);
        for (int n = 0; n <= 70; n++) frame(n, 64, "R7");
        set_cfg(8'd0, 1'b1);
        for (int n = 0; n <= 70; n++) frame(n, 64, "R7");
        // R10: restart during active request needs full threshold again
        set_cfg(8'd8, 1'b1);
        rx_sof = 1'b1; step(); rx_sof = 1'b0;
        for (int i = 1; i <= 16; i++) begin
            rx_byte_vld = 1'b1; step();
        end
        rx_byte_vld = 1'b0;
        chk("R6", dma_req, 1);
        rx_sof = 1'b1; step(); rx_sof = 1'b0;
        chk("R10", dma_req, 0);
        for (int i = 1; i <= 16; i++) begin
            rx_byte_vld = 1'b1; step();
            chk("R10", dma_req, (i >= 16) ? 1 : 0);
        end
        rx_byte_vld = 1'b0;
        // R11: stop drops the request
        ctl_stopped = 1'b1; step();
        chk("R11", dma_req, 0);
        ctl_stopped = 1'b0; step();
        chk("R11", dma_req, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule